// File: doc/BRIEF.md
# Sticky Alarm Interrupt Controller with I2C Target

This block gathers three alarm levels from a receiver front end (loss of signal, over-temperature, supply undervoltage) and makes them visible to a host through an I2C target port. Two byte-wide registers can be read. The first is a history register: it latches every alarm that has occurred and is emptied by a read. The second is a live register: it mirrors the present alarm levels and is never emptied.

A host selects a register by writing a one-byte pointer. It then reads one or more bytes. The pointer steps forward after every byte that is read, so both registers can be fetched in a single burst. The alarm thresholds and hysteresis are computed upstream. The alarms arrive as levels that are synchronous to the block clock. The bus lines are sampled through synchronisers. The data line is driven open-drain through an enable that pulls it low.

Top module: `alarm_irq_i2c`

## Requirements
- R1: The target acknowledges only the 7-bit address 1101001b (byte D2h to write, D3h to read). Any other address receives no acknowledge and leaves SDA released.
- R2: Both registers use the same bit layout: bit 0 is loss of signal, bit 1 is temperature alarm, bit 2 is supply alarm, and bits 7:3 read as 0. The history register sets a bit when its alarm is high for at least one clock, and the bit stays set until a read of pointer 00h.
- R3: A read of pointer 00h returns the history value from before the clear, then clears every history bit.
- R4: An alarm that is still high when the history register clears sets its bit again at once, so the next read of 00h shows it.
- R5: Pointer 01h returns the live alarm levels. Reading it never clears it and never alters the history register.
- R6: The first data byte of a write transaction sets the pointer. Further data bytes in the same write are acknowledged and have no effect.
- R7: The pointer advances by one (modulo 256) after every byte read, and this carries across transactions. Pointers other than 00h and 01h read as 00h.
- R8: A synchronous active-high reset clears both registers and the pointer, releases SDA and returns the bus engine to idle.
- R9: The SDA pull-down changes only while SCL is low.
- R10: An alarm that is high only in the cycle in which a clear takes effect is kept in the history register and is not lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | I2C clock line, asynchronous |
| sda_in | input | 1 | I2C data line as seen on the bus, asynchronous |
| alarm_in | input | 3 | Alarm levels: bit 0 loss of signal, bit 1 temperature, bit 2 supply |
| sda_oe | output | 1 | When high, pulls SDA low |

## Verification
A stuck or lost history bit shows up in the first read of pointer 00h after the alarm fires. A clear that happens at the wrong time shows up as a non-zero value on the read straight after, or as an alarm that is missing from it. A pointer that goes wrong is seen in the very next byte the host receives, for example when it reads a register twice or moves through a burst. A bus engine in the wrong state either stops acknowledging its own address or acknowledges a foreign one, and this is visible within nine SCL periods.

// File: rtl/alm_pkg.sv
package alm_pkg;

  localparam int REG_HIST_A = 0;
  localparam int REG_LIVE_A = 1;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_WR,
    S_WACK,
    S_RD,
    S_MACK
  } tgt_st_t;

endpackage

// File: rtl/alm_sync.sv
module alm_sync #(
  parameter int          STAGES  = 2,
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
  import alm_pkg::*;
#(
  parameter int            DW       = 8,
  parameter logic [DW-2:0] DEV_ADDR = 7'h69,
  localparam int           BW       = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [DW-1:0] rd_data,
  output logic          rd_req,
  output logic [DW-1:0] ptr,
  output logic          sda_oe
);

  localparam logic [BW-1:0] LAST = BW'(DW - 1);

  tgt_st_t       st;
  logic          scl_q, sda_q;
  logic [DW-1:0] shreg, tx;
  logic [BW-1:0] bitcnt;
  logic          byte_done, rw, first_wr, nack;
  logic          scl_rise, scl_fall, start_c, stop_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_c  = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c   = scl_i & scl_q & ~sda_q & sda_i;

  always_comb begin
    rd_req = scl_fall && ((st == S_AACK && rw) || (st == S_MACK && !nack));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      shreg     <= '0;
      tx        <= '0;
      bitcnt    <= '0;
      byte_done <= 1'b0;
      rw        <= 1'b0;
      first_wr  <= 1'b0;
      nack      <= 1'b0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
    end else if (start_c) begin
      st        <= S_ADDR;
      bitcnt    <= '0;
      byte_done <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (stop_c) begin
      st        <= S_IDLE;
      byte_done <= 1'b0;
      sda_oe    <= 1'b0;
    end else begin
      if (scl_rise) begin
        case (st)
          S_ADDR, S_WR: begin
            shreg  <= {shreg[DW-2:0], sda_i};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == LAST) byte_done <= 1'b1;
          end
          S_MACK: nack <= sda_i;
          default: ;
        endcase
      end
      if (scl_fall) begin
        case (st)
          S_ADDR: begin
            if (byte_done) begin
              byte_done <= 1'b0;
              if (shreg[DW-1:1] == DEV_ADDR) begin
                rw     <= shreg[0];
                sda_oe <= 1'b1;
                st     <= S_AACK;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_AACK: begin
            bitcnt <= '0;
            if (rw) begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[DW-1];
              st     <= S_RD;
            end else begin
              sda_oe   <= 1'b0;
              first_wr <= 1'b1;
              st       <= S_WR;
            end
          end
          S_WR: begin
            if (byte_done) begin
              byte_done <= 1'b0;
              sda_oe    <= 1'b1;
              st        <= S_WACK;
              if (first_wr) begin
                ptr      <= shreg;
                first_wr <= 1'b0;
              end
            end
          end
          S_WACK: begin
            sda_oe <= 1'b0;
            st     <= S_WR;
          end
          S_RD: begin
            if (bitcnt == LAST) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              ptr    <= ptr + 1'b1;
              st     <= S_MACK;
            end else begin
              tx     <= {tx[DW-2:0], 1'b0};
              sda_oe <= ~tx[DW-2];
              bitcnt <= bitcnt + 1'b1;
            end
          end
          S_MACK: begin
            if (nack) begin
              st <= S_IDLE;
            end else begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[DW-1];
              bitcnt <= '0;
              st     <= S_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9: the pull-down only moves in a cycle that follows a low SCL sample
  a_r9_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_i));

  // R1: an acknowledge after an address byte needs a matching address
  a_r1_ack_own: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_oe) && $past(st) == S_ADDR) |-> ($past(shreg[DW-1:1]) == DEV_ADDR));

  // R7: leaving a data byte steps the pointer by exactly one
  a_r7_ptr_step: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == S_RD && st == S_MACK) |-> (ptr == $past(ptr) + 1'b1));

  // R8: reset leaves the engine idle with SDA released
  a_r8_idle_after_rst: assert property (@(posedge clk)
    rst |=> (st == S_IDLE && !sda_oe && ptr == '0));

endmodule

// File: rtl/alm_regs.sv
module alm_regs
  import alm_pkg::*;
#(
  parameter int ALM_N = 3,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ALM_N-1:0] alarm_in,
  input  logic [DW-1:0]    ptr,
  input  logic             rd_req,
  output logic [DW-1:0]    rd_data
);

  logic [ALM_N-1:0] hist, live;
  logic             clr;

  assign clr = rd_req && (ptr == DW'(REG_HIST_A));

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      live <= '0;
    end else begin
      live <= alarm_in;
      hist <= (clr ? '0 : hist) | alarm_in;
    end
  end

  always_comb begin
    rd_data = '0;
    if (ptr == DW'(REG_HIST_A))      rd_data[ALM_N-1:0] = hist;
    else if (ptr == DW'(REG_LIVE_A)) rd_data[ALM_N-1:0] = live;
  end

  // R2: outside a clear, no history bit ever drops
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((hist & $past(hist)) == $past(hist)));

  // R3: after a clear only alarms present at that edge remain
  a_r3_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> ((hist & ~$past(alarm_in)) == '0));

  // R10: an alarm coinciding with a clear is kept
  a_r10_keep_event: assert property (@(posedge clk) disable iff (rst)
    clr |=> ((hist & $past(alarm_in)) == $past(alarm_in)));

  // R5: a load from any other pointer leaves history to accumulate only
  a_r5_no_side_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !clr) |=> (hist == ($past(hist) | $past(alarm_in))));

  // R8: both registers come out of reset empty
  a_r8_regs_zero: assert property (@(posedge clk)
    rst |=> (hist == '0 && live == '0));

endmodule

// File: rtl/alarm_irq_i2c.sv
module alarm_irq_i2c #(
  parameter int              DW          = 8,
  parameter int              ALM_N       = 3,
  parameter logic [DW-2:0]   DEV_ADDR    = 7'h69,
  parameter int              SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [ALM_N-1:0] alarm_in,
  output logic             sda_oe
);

  logic [1:0]    bus_s;
  logic [DW-1:0] ptr, rd_data;
  logic          rd_req;

  alm_sync #(
    .STAGES (SYNC_STAGES),
    .W      (2),
    .RST_VAL(2'b11)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  ({scl_in, sda_in}),
    .q  (bus_s)
  );

  i2c_tgt #(
    .DW      (DW),
    .DEV_ADDR(DEV_ADDR)
  ) u_tgt (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (bus_s[1]),
    .sda_i  (bus_s[0]),
    .rd_data(rd_data),
    .rd_req (rd_req),
    .ptr    (ptr),
    .sda_oe (sda_oe)
  );

  alm_regs #(
    .ALM_N(ALM_N),
    .DW   (DW)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .alarm_in(alarm_in),
    .ptr     (ptr),
    .rd_req  (rd_req),
    .rd_data (rd_data)
  );

endmodule

// File: tb/sim_alarm_irq_i2c.sv
module sim_alarm_irq_i2c;

  localparam int HP = 10;
  // upper octal digit: pulse pattern, lower octal digit: held level
  localparam logic [5:0] VEC [8] = '{6'o00, 6'o10, 6'o20, 6'o40,
                                     6'o01, 6'o34, 6'o07, 6'o52};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] alm = 3'b000;
  logic       sda_oe;
  logic       sda_bus;
  logic [7:0] rd_buf [4];
  logic       pulse_at_clear = 1'b0;
  int         checks = 0;
  int         errors = 0;
  int         r9_viol = 0;
  logic       oe_prev = 1'b0;

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  alarm_irq_i2c u0 (
    .clk     (clk),
    .rst     (rst),
    .scl_in  (scl),
    .sda_in  (sda_bus),
    .alarm_in(alm),
    .sda_oe  (sda_oe)
  );

  always @(negedge clk) begin
    if (!rst && sda_oe !== oe_prev && scl) r9_viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; hp();
    scl = 1'b1;   hp();
    sda_m = 1'b0; hp();
    scl = 1'b0;   hp();
  endtask

  task automatic bstop();
    sda_m = 1'b0; hp();
    scl = 1'b1;   hp();
    sda_m = 1'b1; hp();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp();
      scl = 1'b1;   hp();
      scl = 1'b0;
    end
    sda_m = 1'b1; hp();
    scl = 1'b1;   hp();
    ack = ~sda_bus;
    scl = 1'b0;
    if (pulse_at_clear) begin
      @(negedge clk);
      @(negedge clk);
      alm = 3'b001;
      @(negedge clk);
      alm = 3'b000;
      pulse_at_clear = 1'b0;
    end
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp();
      scl = 1'b1; hp();
      b[i] = sda_bus;
      scl = 1'b0;
    end
    sda_m = mack ? 1'b0 : 1'b1; hp();
    scl = 1'b1; hp();
    scl = 1'b0;
    sda_m = 1'b1;
  endtask

  task automatic read_cur(input int n);
    logic a;
    bstart();
    wbyte(8'hD3, a);
    chk("R1 read address ack", {7'b0, a}, 8'h01);
    for (int k = 0; k < n; k++) rbyte(k != n - 1, rd_buf[k]);
    bstop();
  endtask

  task automatic read_regs(input logic [7:0] p, input int n);
    logic a;
    bstart();
    wbyte(8'hD2, a);
    chk("R1 write address ack", {7'b0, a}, 8'h01);
    wbyte(p, a);
    chk("R6 pointer byte ack", {7'b0, a}, 8'h01);
    read_cur(n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    logic a;
    repeat (5) @(negedge clk);
    chk("R8 SDA released in reset", {7'b0, sda_oe}, 8'h00);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    read_regs(8'h00, 2);
    chk("R8 history after reset", rd_buf[0], 8'h00);
    chk("R8 live after reset", rd_buf[1], 8'h00);

    // table walk: R2/R3/R4/R5 across pulse and level patterns
    for (int v = 0; v < 8; v++) begin
      logic [2:0] pl, lv;
      pl = VEC[v][5:3];
      lv = VEC[v][2:0];
      alm = pl; repeat (3) @(negedge clk);
      alm = lv; repeat (3) @(negedge clk);
      read_regs(8'h00, 2);
      chk("R2 history holds pulse and level", rd_buf[0], {5'b0, pl | lv});
      chk("R5 live register after burst step", rd_buf[1], {5'b0, lv});
      read_regs(8'h00, 1);
      chk("R4 still-active alarm set again", rd_buf[0], {5'b0, lv});
      alm = 3'b000;
      read_regs(8'h00, 1);
      chk("R4 re-set bit survives alarm drop", rd_buf[0], {5'b0, lv});
      read_regs(8'h00, 1);
      chk("R3 history empty after clear", rd_buf[0], 8'h00);
    end

    // R1: foreign addresses are not acknowledged
    bstart();
    wbyte(8'hA4, a);
    chk("R1 foreign address no ack", {7'b0, a}, 8'h00);
    bstop();
    bstart();
    wbyte(8'hD0, a);
    chk("R1 near-miss address no ack", {7'b0, a}, 8'h00);
    bstop();

    // R5: live register is never cleared and does not clear history
    alm = 3'b010;
    read_regs(8'h01, 1);
    chk("R5 live first read", rd_buf[0], 8'h02);
    read_regs(8'h01, 1);
    chk("R5 live second read", rd_buf[0], 8'h02);
    alm = 3'b000;
    read_regs(8'h00, 1);
    read_regs(8'h00, 1);
    chk("R3 history cleared before live test", rd_buf[0], 8'h00);
    alm = 3'b001; repeat (3) @(negedge clk);
    alm = 3'b000;
    read_regs(8'h01, 1);
    chk("R5 live follows dropped alarm", rd_buf[0], 8'h00);
    read_regs(8'h00, 1);
    chk("R5 history untouched by live read", rd_buf[0], 8'h01);

    // R7: auto-increment, unmapped pointers and wrap
    alm = 3'b100;
    read_regs(8'h01, 3);
    chk("R7 burst byte 0 live", rd_buf[0], 8'h04);
    chk("R7 burst byte 1 pointer 02h", rd_buf[1], 8'h00);
    chk("R7 burst byte 2 pointer 03h", rd_buf[2], 8'h00);
    read_regs(8'h05, 1);
    chk("R7 unmapped pointer 05h", rd_buf[0], 8'h00);
    read_regs(8'hFF, 2);
    chk("R7 pointer FFh", rd_buf[0], 8'h00);
    chk("R7 wrap to history", rd_buf[1], 8'h04);
    alm = 3'b000;
    read_regs(8'h00, 1);
    read_regs(8'h00, 1);
    chk("R3 history empty after drop", rd_buf[0], 8'h00);

    // R6: extra write bytes have no effect, pointer kept across transactions
    alm = 3'b010; repeat (3) @(negedge clk);
    alm = 3'b000;
    bstart();
    wbyte(8'hD2, a);
    wbyte(8'h00, a);
    wbyte(8'hFF, a);
    chk("R6 extra data byte ack", {7'b0, a}, 8'h01);
    wbyte(8'h01, a);
    bstop();
    read_cur(1);
    chk("R6 pointer from first data byte", rd_buf[0], 8'h02);
    read_cur(1);
    chk("R7 pointer carried to next transaction", rd_buf[0], 8'h00);

    // R10: alarm only in the clearing cycle is retained
    bstart();
    wbyte(8'hD2, a);
    wbyte(8'h00, a);
    bstart();
    pulse_at_clear = 1'b1;
    wbyte(8'hD3, a);
    rbyte(1'b0, rd_buf[0]);
    bstop();
    chk("R10 pre-clear value returned", rd_buf[0], 8'h00);
    read_regs(8'h00, 1);
    chk("R10 event in clear cycle kept", rd_buf[0], 8'h01);

    // R8: reset wipes latched history
    alm = 3'b111; repeat (3) @(negedge clk);
    alm = 3'b000;
    rst = 1'b1; repeat (3) @(negedge clk);
    rst = 1'b0; repeat (3) @(negedge clk);
    read_regs(8'h00, 2);
    chk("R8 history wiped by reset", rd_buf[0], 8'h00);
    chk("R8 live wiped by reset", rd_buf[1], 8'h00);

    chk("R9 no SDA change while SCL high", r9_viol[7:0], 8'h00);
    finish_sim();
  end

endmodule